// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block settles the result of one USB transfer descriptor attempt. A schedule engine hands it the descriptor's 32-bit control word and token word. A bus-side stub supplies the transaction response: a byte count, a NAK, a STALL, or no device/timeout. One clock later the block returns the control word to write back, an outcome code and two interrupt-mask bits. It also raises a single-cycle error flag for the host status register when one applies.

The token fields are also decoded without a register, so the transaction side can start from them in the same cycle the descriptor is presented. These fields are the packet identifier, the device address, the endpoint and the maximum packet length. The block combines several rules into one status update: the two-bit retry counter, short-packet detection, truncation of overlong IN data as babble, and isochronous-select retirement. A NAK to a SETUP token counts as a failed attempt, not as a plain NAK.

Top module: `td_outcome_unit`

## Requirements
- R1: Bit 24 of the control word (interrupt on completion) sets bit 0 of the interrupt-mask output for every accepted descriptor. This includes descriptors that are inactive or carry an illegal PID.
- R2: When bit 23 (active) of the control word is clear, the outcome is skip (code 2'b01), the returned control word equals the input, and both error flags stay low.
- R3: The decode outputs are combinational from the token word. PID is bits [7:0], device address is bits [14:8], endpoint is bits [18:15], and maximum length is (bits [31:21] + 1) modulo 2048.
- R4: For an active descriptor whose PID is not SETUP (0x2D), IN (0x69) or OUT (0xE1), the process-error flag rises, the outcome is abort (2'b10) and the control word is returned unchanged.
- R5: A data response (kind 2'b00) that is not babble writes length minus one into control bits [10:0] and clears active, and the outcome is success (2'b00). For OUT and SETUP the length is the maximum length; for IN it is the response byte count.
- R6: An IN success with bit 29 (short-packet detect) set and a length below the maximum sets mask bit 1, and the outcome is skip instead of success.
- R7: An IN byte count above the maximum length sets bits 20 and 22, clears active and leaves bits [10:0] unchanged. The outcome is abort.
- R8: On no-device/timeout (kind 2'b11), bit 18 is set and a nonzero count in bits [28:27] is decremented. When the count reaches zero, active is cleared and the USB-error flag rises. A zero count stays zero with no flag. The outcome is skip.
- R9: On NAK (kind 2'b01) to IN or OUT, bit 19 is set, active is left as it was and the outcome is skip.
- R10: A NAK to SETUP sets bit 19 and also follows the R8 timeout path.
- R11: On STALL (kind 2'b10), bit 22 is set, active is cleared and the outcome is skip.
- R12: With bit 25 (isochronous select) set, any attempt on an active descriptor with a legal PID returns active cleared, whatever the response.
- R13: Synchronous active-high reset clears all registered outputs. A result appears, with done_valid high for one cycle, exactly one clock after the cycle where req_valid was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Descriptor and response presented this cycle |
| ctrl_in | input | 32 | Descriptor control word |
| token_in | input | 32 | Descriptor token word |
| rsp_kind | input | 2 | Response: 0 data, 1 NAK, 2 STALL, 3 no device/timeout |
| rsp_len | input | RSP_W | Byte count returned by an IN transaction |
| dec_pid | output | 8 | Decoded packet identifier |
| dec_addr | output | 7 | Decoded device address |
| dec_ep | output | 4 | Decoded endpoint number |
| dec_maxlen | output | 11 | Decoded maximum length |
| done_valid | output | 1 | Result valid (one cycle after req_valid) |
| ctrl_out | output | 32 | Updated control word |
| outcome | output | 2 | 0 success, 1 skip, 2 abort |
| irq_mask | output | 2 | Bit 0 completion interrupt, bit 1 short packet |
| flag_uerr | output | 1 | USB error (retries exhausted) |
| flag_perr | output | 1 | Host process error (illegal PID) |

## Verification
Two functions can clear the active bit in the same attempt. One is isochronous-select retirement. The other is retry exhaustion on a timeout or on a NAK to SETUP. The bench provokes this with directed descriptors that have bit 25 set and an error count of one. It checks that active is cleared, the count reads zero, bit 18 is set and the USB-error flag rises exactly once. A second collision is short-packet detection together with the completion interrupt: both mask bits must come back set from one descriptor. Random descriptors that mix both bits with every response kind cover the remaining overlaps against the bench model.

// File: rtl/td_pkg.sv
package td_pkg;
  localparam int CW      = 32;
  localparam int LEN_LO  = 21;
  localparam int LEN_W   = CW - LEN_LO;
  localparam int CNT_W   = 2;

  // control word bit positions
  localparam int B_SPD   = 29;
  localparam int B_ERRLO = 27;
  localparam int B_IOS   = 25;
  localparam int B_IOC   = 24;
  localparam int B_ACT   = 23;
  localparam int B_STALL = 22;
  localparam int B_BABL  = 20;
  localparam int B_NAK   = 19;
  localparam int B_TMO   = 18;

  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;

  localparam logic [1:0] RK_DATA  = 2'd0;
  localparam logic [1:0] RK_NAK   = 2'd1;
  localparam logic [1:0] RK_STALL = 2'd2;
  localparam logic [1:0] RK_NODEV = 2'd3;

  typedef enum logic [1:0] {
    OC_SUCCESS = 2'b00,
    OC_SKIP    = 2'b01,
    OC_ABORT   = 2'b10
  } outcome_e;

  typedef struct packed {
    logic [CW-1:0] ctrl;
    outcome_e      oc;
    logic [1:0]    mask;
    logic          uerr;
    logic          perr;
  } td_result_t;
endpackage

// File: rtl/td_token_dec.sv
module td_token_dec
  import td_pkg::*;
(
  input  logic [CW-1:0]    token,
  output logic [7:0]       pid,
  output logic [6:0]       addr,
  output logic [3:0]       ep,
  output logic [LEN_W-1:0] maxlen,
  output logic             pid_ok,
  output logic             pid_in,
  output logic             pid_setup
);
  logic [1:0] unused_bits;
  assign unused_bits = token[20:19];

  assign pid       = token[7:0];
  assign addr      = token[14:8];
  assign ep        = token[18:15];
  assign maxlen    = token[CW-1:LEN_LO] + LEN_W'(1);
  assign pid_in    = (pid == PID_IN);
  assign pid_setup = (pid == PID_SETUP);
  assign pid_ok    = pid_in || pid_setup || (pid == PID_OUT);
endmodule

// File: rtl/td_retry_dec.sv
module td_retry_dec #(
  parameter int W = 2
) (
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cnt_next,
  output logic         exhausted
);
  always_comb begin
    if (cnt == '0) begin
      cnt_next  = '0;
      exhausted = 1'b0;
    end else begin
      cnt_next  = cnt - W'(1);
      exhausted = (cnt == W'(1));
    end
  end
endmodule

// File: rtl/td_status_calc.sv
module td_status_calc
  import td_pkg::*;
#(
  parameter int RSP_W = 12
) (
  input  logic [CW-1:0]    ctrl_in,
  input  logic             pid_ok,
  input  logic             pid_in,
  input  logic             pid_setup,
  input  logic [LEN_W-1:0] maxlen,
  input  logic [1:0]       rsp_kind,
  input  logic [RSP_W-1:0] rsp_len,
  output td_result_t       res
);
  logic [CNT_W-1:0] cnt_next;
  logic             cnt_exh;
  logic [RSP_W-1:0] max_ext;
  logic [RSP_W-1:0] len;
  logic [CW-1:0]    c;
  logic             tmo;

  td_retry_dec #(.W(CNT_W)) u_retry (
    .cnt      (ctrl_in[B_ERRLO +: CNT_W]),
    .cnt_next (cnt_next),
    .exhausted(cnt_exh)
  );

  assign max_ext = RSP_W'(maxlen);
  assign len     = pid_in ? rsp_len : max_ext;

  always_comb begin
    res      = '0;
    res.ctrl = ctrl_in;
    res.oc   = OC_SKIP;
    res.mask = {1'b0, ctrl_in[B_IOC]};
    c        = ctrl_in;
    tmo      = 1'b0;
    if (ctrl_in[B_ACT]) begin
      if (!pid_ok) begin
        res.perr = 1'b1;
        res.oc   = OC_ABORT;
      end else begin
        if (ctrl_in[B_IOS]) c[B_ACT] = 1'b0;
        case (rsp_kind)
          RK_DATA: begin
            if (pid_in && (rsp_len > max_ext)) begin
              c[B_BABL]  = 1'b1;
              c[B_STALL] = 1'b1;
              c[B_ACT]   = 1'b0;
              res.oc     = OC_ABORT;
            end else begin
              c[LEN_W-1:0] = len[LEN_W-1:0] - LEN_W'(1);
              c[B_ACT]     = 1'b0;
              if (pid_in && ctrl_in[B_SPD] && (len < max_ext)) begin
                res.mask[1] = 1'b1;
                res.oc      = OC_SKIP;
              end else begin
                res.oc = OC_SUCCESS;
              end
            end
          end
          RK_NAK: begin
            c[B_NAK] = 1'b1;
            tmo      = pid_setup;
          end
          RK_STALL: begin
            c[B_STALL] = 1'b1;
            c[B_ACT]   = 1'b0;
          end
          default: tmo = 1'b1;
        endcase
        if (tmo) begin
          c[B_TMO]               = 1'b1;
          c[B_ERRLO +: CNT_W]    = cnt_next;
          if (cnt_exh) begin
            c[B_ACT] = 1'b0;
            res.uerr = 1'b1;
          end
        end
        res.ctrl = c;
      end
    end
  end
endmodule

// File: rtl/td_outcome_unit.sv
module td_outcome_unit
  import td_pkg::*;
#(
  parameter int RSP_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [31:0]      ctrl_in,
  input  logic [31:0]      token_in,
  input  logic [1:0]       rsp_kind,
  input  logic [RSP_W-1:0] rsp_len,
  output logic [7:0]       dec_pid,
  output logic [6:0]       dec_addr,
  output logic [3:0]       dec_ep,
  output logic [10:0]      dec_maxlen,
  output logic             done_valid,
  output logic [31:0]      ctrl_out,
  output logic [1:0]       outcome,
  output logic [1:0]       irq_mask,
  output logic             flag_uerr,
  output logic             flag_perr
);
  logic       pid_ok, pid_in, pid_setup;
  td_result_t res_d, res_q;
  logic       done_q;

  td_token_dec u_dec (
    .token    (token_in),
    .pid      (dec_pid),
    .addr     (dec_addr),
    .ep       (dec_ep),
    .maxlen   (dec_maxlen),
    .pid_ok   (pid_ok),
    .pid_in   (pid_in),
    .pid_setup(pid_setup)
  );

  td_status_calc #(.RSP_W(RSP_W)) u_calc (
    .ctrl_in  (ctrl_in),
    .pid_ok   (pid_ok),
    .pid_in   (pid_in),
    .pid_setup(pid_setup),
    .maxlen   (dec_maxlen),
    .rsp_kind (rsp_kind),
    .rsp_len  (rsp_len),
    .res      (res_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= req_valid;
      if (req_valid) res_q <= res_d;
    end
  end

  assign done_valid = done_q;
  assign ctrl_out   = res_q.ctrl;
  assign outcome    = res_q.oc;
  assign irq_mask   = res_q.mask;
  assign flag_uerr  = res_q.uerr && done_q;
  assign flag_perr  = res_q.perr && done_q;
endmodule

// File: rtl/td_outcome_chk.sv
module td_outcome_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] ctrl_in,
  input logic [31:0] token_in,
  input logic [1:0]  rsp_kind,
  input logic        done_valid,
  input logic [31:0] ctrl_out,
  input logic [1:0]  outcome,
  input logic [1:0]  irq_mask,
  input logic        flag_uerr,
  input logic        flag_perr
);
  logic legal_pid;
  assign legal_pid = (token_in[7:0] == 8'h2D) || (token_in[7:0] == 8'h69) ||
                     (token_in[7:0] == 8'hE1);

  a_r13_done_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done_valid);

  a_r1_ioc_mask: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (irq_mask[0] == $past(ctrl_in[24])));

  a_r2_inactive_kept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ctrl_in[23]) |=> (ctrl_out == $past(ctrl_in)) && (outcome == 2'b01));

  a_r4_perr_aborts: assert property (@(posedge clk) disable iff (rst)
    flag_perr |-> (outcome == 2'b10) && done_valid);

  a_r11_stall_retires: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ctrl_in[23] && legal_pid && rsp_kind == 2'd2) |=>
      (!ctrl_out[23] && ctrl_out[22] && outcome == 2'b01));

  a_r8_uerr_state: assert property (@(posedge clk) disable iff (rst)
    flag_uerr |-> (!ctrl_out[23] && ctrl_out[18] && ctrl_out[28:27] == 2'b00));

  a_r12_iso_retires: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ctrl_in[23] && ctrl_in[25] && legal_pid) |=> !ctrl_out[23]);

  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_uerr, flag_perr}));
endmodule

bind td_outcome_unit td_outcome_chk u_chk (.*);

// File: tb/sim_td_outcome_unit.sv
`timescale 1ns/1ps
module sim_td_outcome_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] ctrl_in = '0;
  logic [31:0] token_in = '0;
  logic [1:0]  rsp_kind = '0;
  logic [11:0] rsp_len = '0;
  logic [7:0]  dec_pid;
  logic [6:0]  dec_addr;
  logic [3:0]  dec_ep;
  logic [10:0] dec_maxlen;
  logic        done_valid;
  logic [31:0] ctrl_out;
  logic [1:0]  outcome;
  logic [1:0]  irq_mask;
  logic        flag_uerr, flag_perr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  td_outcome_unit #(.RSP_W(12)) u0 (.*);

  function automatic logic [37:0] model(input logic [31:0] c, input logic [31:0] t,
                                        input logic [1:0] k, input logic [11:0] n);
    logic [31:0] o;
    logic [1:0]  oc, m;
    logic        ue, pe, tmo;
    logic [10:0] mx;
    logic [11:0] mxe, L;
    logic [7:0]  p;
    o = c; oc = 2'b01; m = {1'b0, c[24]}; ue = 0; pe = 0; tmo = 0;
    mx = t[31:21] + 11'd1; mxe = {1'b0, mx}; p = t[7:0];
    L = (p == 8'h69) ? n : mxe;
    if (c[23]) begin
      if (p != 8'h2D && p != 8'h69 && p != 8'hE1) begin
        pe = 1; oc = 2'b10;
      end else begin
        if (c[25]) o[23] = 0;
        if (k == 2'd0) begin
          if (p == 8'h69 && n > mxe) begin
            o[20] = 1; o[22] = 1; o[23] = 0; oc = 2'b10;
          end else begin
            o[10:0] = L[10:0] - 11'd1; o[23] = 0;
            if (p == 8'h69 && c[29] && L < mxe) begin m[1] = 1; oc = 2'b01; end
            else oc = 2'b00;
          end
        end else if (k == 2'd1) begin
          o[19] = 1; tmo = (p == 8'h2D);
        end else if (k == 2'd2) begin
          o[22] = 1; o[23] = 0;
        end else tmo = 1;
        if (tmo) begin
          o[18] = 1;
          if (c[28:27] != 2'd0) begin
            o[28:27] = c[28:27] - 2'd1;
            if (c[28:27] == 2'd1) begin o[23] = 0; ue = 1; end
          end
        end
      end
    end
    return {o, oc, m, ue, pe};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] c, input logic [31:0] t,
                     input logic [1:0] k, input logic [11:0] n);
    logic [37:0] e;
    logic [10:0] mx;
    @(negedge clk);
    ctrl_in = c; token_in = t; rsp_kind = k; rsp_len = n; req_valid = 1'b1;
    #1;
    mx = t[31:21] + 11'd1;
    chk("R3 decode", 64'({dec_pid, dec_addr, dec_ep, dec_maxlen}),
        64'({t[7:0], t[14:8], t[18:15], mx}));
    e = model(c, t, k, n);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R13 result"}, 64'({done_valid, ctrl_out, outcome, irq_mask, flag_uerr, flag_perr}),
        64'({1'b1, e}));
  endtask

  function automatic logic [31:0] tok(input logic [7:0] p, input logic [10:0] mf);
    return {mf, 2'b00, 4'h3, 7'h15, p};
  endfunction

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13 reset", 64'({done_valid, ctrl_out, outcome, irq_mask, flag_uerr, flag_perr}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 idle", 64'(done_valid), 64'd0);

    run("R1 R2 inactive ioc", 32'h0100_0000, tok(8'h69, 11'd7), 2'd2, 12'd3);
    run("R1 R4 bad pid", 32'h0180_0000, tok(8'h55, 11'd7), 2'd0, 12'd8);
    run("R5 out", 32'h1880_0000, tok(8'hE1, 11'd7), 2'd0, 12'd0);
    run("R5 setup", 32'h0880_0000, tok(8'h2D, 11'd63), 2'd0, 12'd0);
    run("R5 in full", 32'h2080_0000, tok(8'h69, 11'd15), 2'd0, 12'd16);
    run("R6 short spd", 32'h2180_0000, tok(8'h69, 11'd15), 2'd0, 12'd4);
    run("R6 short no spd", 32'h0080_0000, tok(8'h69, 11'd15), 2'd0, 12'd4);
    run("R7 babble", 32'h0080_0123, tok(8'h69, 11'd15), 2'd0, 12'd17);
    run("R8 retry 3", 32'h1880_0000, tok(8'hE1, 11'd3), 2'd3, 12'd0);
    run("R8 retry 1", 32'h0880_0000, tok(8'h69, 11'd3), 2'd3, 12'd0);
    run("R8 retry 0", 32'h0080_0000, tok(8'h69, 11'd3), 2'd3, 12'd0);
    run("R9 nak in", 32'h1880_0000, tok(8'h69, 11'd3), 2'd1, 12'd0);
    run("R10 nak setup", 32'h0880_0000, tok(8'h2D, 11'd3), 2'd1, 12'd0);
    run("R11 stall", 32'h1880_0000, tok(8'hE1, 11'd3), 2'd2, 12'd0);
    run("R12 iso nak", 32'h0280_0000, tok(8'h69, 11'd3), 2'd1, 12'd0);
    run("R12 iso retry exhaust", 32'h0A80_0000, tok(8'hE1, 11'd3), 2'd3, 12'd0);
    run("R3 R5 zero max", 32'h0080_0000, tok(8'hE1, 11'h7FF), 2'd0, 12'd0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] c, t;
      logic [7:0]  p;
      logic [11:0] n;
      int sel;
      sel = $urandom_range(0, 7);
      p = (sel < 2) ? 8'h69 : (sel < 4) ? 8'hE1 : (sel < 6) ? 8'h2D : 8'($urandom);
      c = $urandom;
      if ($urandom_range(0, 3) != 0) c[23] = 1'b1;
      t = $urandom;
      t[31:21] = 11'($urandom_range(0, 40));
      t[7:0] = p;
      n = 12'($urandom_range(0, 45));
      run("R5 R6 R7 R8 R12 random", c, t, 2'($urandom), n);
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule